// File: doc/BRIEF.md
# Maskable Event Interrupt Status Controller

This block gathers single-cycle event pulses from an encoder subsystem and a decoder subsystem into one 32-bit pending-status word. It drives a single level interrupt line to the host. Each event source owns a fixed bit in the upper part of the word. Software can inject any of those bits by writing a raise register. It acknowledges pending bits by writing ones back to the status register.

A 32-bit block mask decides which pending bits reach the host line. The mask is active-low as an enable: a mask bit of 0 lets its status bit through, and a 1 blocks it. After reset every mask bit is 1, so nothing interrupts the host until software opens a bit.

The register bus is deliberately minimal. A write takes effect in the cycle it is presented. A read returns its data one cycle after the read strobe.

Top module: `evtIrqTop`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFFFFFFFF, and `irqOut` is 0.
- R2: A one-cycle pulse on `encEvt[i]` sets status bit 27+i at the next clock edge: bit 0 maps to 27 (DMA complete), 1 to 28 (video input reset), 2 to 29 (VBI capture), 3 to 30 (end of stream) and 4 to 31 (start capture).
- R3: A one-cycle pulse on `decEvt[i]` sets one status bit at the next edge: bit 0 maps to 18 (descriptor-list error), 1 to 19 (VBI re-insertion), 2 to 20 (DMA complete), 3 to 21 (I-frame done), 4 to 22 (data request), 5 to 24 (audio mode change) and 6 to 25 (copy-protect detected).
- R4: Writing the raise register at byte address 0x8 sets every status bit written as 1 among bits 31..18, including bits 26 and 23, which have no hardware source. Raise-register bits written as 0 have no effect.
- R5: Writing the status register at byte address 0x4 clears every status bit written as 1 and leaves bits written as 0 unchanged. A status bit never falls without such a write.
- R6: When a hardware event sets a bit in the same cycle that a status write clears it, the bit ends set.
- R7: The mask register at byte address 0x0 is read/write and 32 bits wide. `irqOut` is 1 exactly when some status bit is 1 while its mask bit is 0. When every mask bit is 1, `irqOut` is 0.
- R8: `irqOut` is registered. It changes one clock after the status or mask change that causes it.
- R9: Read data appears on `busRdData` in the cycle after `busRdEn`. The raise register and the unmapped address 0xC read as zero. In a cycle after no read, `busRdData` is zero.
- R10: Status bits 17..0 always read zero, even when they are written as 1 to the raise register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busAddr | input | 4 | Byte address. The word index is in bits 3..2, and bits 1..0 must be zero for the access to take effect |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| encEvt | input | 5 | Encoder event pulses |
| decEvt | input | 7 | Decoder event pulses |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The checker watches these behaviours on every cycle:
- An encoder or decoder pulse always leaves its bit set at the next edge, even under a simultaneous clear.
- A raise write sets its bits.
- No status bit falls without a status write.
- The reserved low bits stay zero.
- A fully closed mask keeps the line low.
- Read data is zero after a cycle with no read.

Only the bench scenarios can show the rest:
- The exact bit map of each source.
- Partial clears that leave the other bits alone.
- The reset values.
- The one-cycle lag of `irqOut` as the mask opens and as bits clear.

// File: rtl/evtIrqPkg.sv
package evtIrqPkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int ENC_N   = 5;
  localparam int DEC_N   = 7;
  localparam int LIVE_LO = 18;
  localparam int ENC_LO  = 27;

  // word indices of the registers on the bus
  localparam int IDX_MASK  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_RAISE = 2;

  localparam logic [DATA_W-1:0] LIVE_BITS =
    {{(DATA_W-LIVE_LO){1'b1}}, {LIVE_LO{1'b0}}};

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrClear;
    logic   wrRaise;
    rdSel_e rdSel;
  } strobes_t;

  function automatic int encBitPos(input int i);
    return ENC_LO + i;
  endfunction

  // decoder bits skip position 23
  function automatic int decBitPos(input int i);
    return (i < 5) ? (LIVE_LO + i) : (LIVE_LO + 1 + i);
  endfunction
endpackage

// File: rtl/evtIrqCtrl.sv
module evtIrqCtrl
  import evtIrqPkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W
) (
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_WIDTH-1:0] busAddr,
  output strobes_t              ctl
);
  localparam int WORD_W = ADDR_WIDTH - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              hitMask;
  logic              hitStat;
  logic              hitRaise;

  assign wordIdx  = busAddr[ADDR_WIDTH-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign hitMask  = aligned && (wordIdx == WORD_W'(IDX_MASK));
  assign hitStat  = aligned && (wordIdx == WORD_W'(IDX_STAT));
  assign hitRaise = aligned && (wordIdx == WORD_W'(IDX_RAISE));

  always_comb begin
    ctl.wrMask  = busWrEn && hitMask;
    ctl.wrClear = busWrEn && hitStat;
    ctl.wrRaise = busWrEn && hitRaise;
    if (busRdEn && hitMask)      ctl.rdSel = RD_MASK;
    else if (busRdEn && hitStat) ctl.rdSel = RD_STAT;
    else                         ctl.rdSel = RD_NONE;
  end
endmodule

// File: rtl/evtIrqMap.sv
module evtIrqMap
  import evtIrqPkg::*;
#(
  parameter int DATA_WIDTH = DATA_W,
  parameter int ENC_COUNT  = ENC_N,
  parameter int DEC_COUNT  = DEC_N
) (
  input  logic [ENC_COUNT-1:0]  encEvt,
  input  logic [DEC_COUNT-1:0]  decEvt,
  output logic [DATA_WIDTH-1:0] hwSet
);
  always_comb begin
    hwSet = '0;
    for (int i = 0; i < ENC_COUNT; i++) hwSet[encBitPos(i)] = encEvt[i];
    for (int j = 0; j < DEC_COUNT; j++) hwSet[decBitPos(j)] = decEvt[j];
  end
endmodule

// File: rtl/evtIrqDatapath.sv
module evtIrqDatapath
  import evtIrqPkg::*;
#(
  parameter int DATA_WIDTH = DATA_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              ctl,
  input  logic [DATA_WIDTH-1:0] busWrData,
  input  logic [DATA_WIDTH-1:0] hwSet,
  output logic [DATA_WIDTH-1:0] statusQ,
  output logic [DATA_WIDTH-1:0] maskQ,
  output logic [DATA_WIDTH-1:0] rdData,
  output logic                  irqOut
);
  logic [DATA_WIDTH-1:0] clrBits;
  logic [DATA_WIDTH-1:0] swSet;
  logic [DATA_WIDTH-1:0] statusD;
  logic [DATA_WIDTH-1:0] rdD;

  assign clrBits = ctl.wrClear ? busWrData : '0;
  assign swSet   = ctl.wrRaise ? busWrData : '0;
  // sets are applied after the clear so they win
  assign statusD = ((statusQ & ~clrBits) | hwSet | swSet) & LIVE_BITS;

  always_comb begin
    unique case (ctl.rdSel)
      RD_MASK: rdD = maskQ;
      RD_STAT: rdD = statusQ;
      default: rdD = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
      rdData  <= '0;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (ctl.wrMask) maskQ <= busWrData;
      rdData  <= rdD;
      irqOut  <= |(statusQ & ~maskQ);
    end
  end
endmodule

// File: rtl/evtIrqTop.sv
module evtIrqTop
  import evtIrqPkg::*;
#(
  parameter int DATA_WIDTH = DATA_W,
  parameter int ADDR_WIDTH = ADDR_W,
  parameter int ENC_COUNT  = ENC_N,
  parameter int DEC_COUNT  = DEC_N
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_WIDTH-1:0] busAddr,
  input  logic [DATA_WIDTH-1:0] busWrData,
  output logic [DATA_WIDTH-1:0] busRdData,
  input  logic [ENC_COUNT-1:0]  encEvt,
  input  logic [DEC_COUNT-1:0]  decEvt,
  output logic                  irqOut
);
  strobes_t              ctl;
  logic [DATA_WIDTH-1:0] hwSet;
  logic [DATA_WIDTH-1:0] statusQ;
  logic [DATA_WIDTH-1:0] maskQ;

  evtIrqCtrl #(.ADDR_WIDTH(ADDR_WIDTH)) uCtrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .ctl(ctl)
  );

  evtIrqMap #(
    .DATA_WIDTH(DATA_WIDTH), .ENC_COUNT(ENC_COUNT), .DEC_COUNT(DEC_COUNT)
  ) uMap (
    .encEvt(encEvt), .decEvt(decEvt), .hwSet(hwSet)
  );

  evtIrqDatapath #(.DATA_WIDTH(DATA_WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWrData(busWrData),
    .hwSet(hwSet), .statusQ(statusQ), .maskQ(maskQ),
    .rdData(busRdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/evtIrqChecker.sv
module evtIrqChecker
  import evtIrqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [ENC_N-1:0]  encEvt,
  input logic [DEC_N-1:0]  decEvt,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] maskQ,
  input logic              irqOut
);
  AST_ENC_TOP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    encEvt[4] |=> statusQ[31]); // R2
  AST_DEC_ERR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    decEvt[0] |=> statusQ[18]); // R3
  AST_ENC_LOW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (encEvt[0] && busWrEn && busAddr == 4'h4 && busWrData[27]) |=> statusQ[27]); // R6
  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'h8 && busWrData[26]) |=> statusQ[26]); // R4
  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 4'h4) |=> (($past(statusQ) & ~statusQ) == '0)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[LIVE_LO-1:0] == '0); // R10
  AST_CLOSED_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1) |=> !irqOut); // R7
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0)); // R9
endmodule

bind evtIrqTop evtIrqChecker uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .encEvt(encEvt), .decEvt(decEvt), .statusQ(statusQ), .maskQ(maskQ),
  .irqOut(irqOut)
);

// File: tb/test_evtIrqTop.sv
`timescale 1ns/1ps
module test_evtIrqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [4:0]  encEvt = '0;
  logic [6:0]  decEvt = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  evtIrqTop i_evtIrqTop (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .encEvt(encEvt), .decEvt(decEvt), .irqOut(irqOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value one cycle after the read strobe
  always @(posedge clk) begin
    #1;
    if (rstN && busRdEn) begin
      if (expQ.size() == 0) check(busRdData, 32'hDEAD_BEEF, "unexpected read");
      else check(busRdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic busRead(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [4:0] e, input logic [6:0] d);
    @(negedge clk);
    encEvt = e; decEvt = d;
    @(negedge clk);
    encEvt = '0; decEvt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busRead(4'h0, 32'hFFFF_FFFF, "R1 mask reset");
    busRead(4'h4, 32'h0000_0000, "R1 status reset");
    check({31'd0, irqOut}, 32'd0, "R1 irq reset");

    pulseEvt(5'b10001, 7'd0);
    busRead(4'h4, 32'h8800_0000, "R2 encoder bits 31 and 27");
    check({31'd0, irqOut}, 32'd0, "R7 closed mask keeps irq low");
    busWrite(4'h4, 32'h8800_0000);
    busRead(4'h4, 32'h0000_0000, "R5 clear encoder bits");

    pulseEvt(5'b01110, 7'd0);
    busRead(4'h4, 32'h7000_0000, "R2 encoder bits 30..28");
    busWrite(4'h4, 32'hFFFF_FFFF);

    pulseEvt(5'd0, 7'b0000100);
    busRead(4'h4, 32'h0010_0000, "R3 decoder bit 2 to status 20");
    pulseEvt(5'd0, 7'b1111111);
    busRead(4'h4, 32'h037C_0000, "R3 all decoder bits");
    busWrite(4'h4, 32'h0100_0000);
    busRead(4'h4, 32'h027C_0000, "R5 partial clear");
    busWrite(4'h4, 32'hFFFF_FFFF);
    busRead(4'h4, 32'h0000_0000, "R5 clear all");

    busWrite(4'h8, 32'h8480_FFFF);
    busRead(4'h4, 32'h8480_0000, "R4 R10 raise, reserved stay zero");
    busRead(4'h8, 32'h0000_0000, "R9 raise reads zero");
    busRead(4'hC, 32'h0000_0000, "R9 unmapped reads zero");

    busWrite(4'h0, 32'hFBFF_FFFF);
    check({31'd0, irqOut}, 32'd0, "R8 irq lags mask by one cycle");
    @(negedge clk);
    check({31'd0, irqOut}, 32'd1, "R7 unmasked bit 26 raises irq");
    busRead(4'h0, 32'hFBFF_FFFF, "R7 mask readback");

    busWrite(4'h4, 32'h0400_0000);
    check({31'd0, irqOut}, 32'd1, "R8 irq lags clear by one cycle");
    @(negedge clk);
    check({31'd0, irqOut}, 32'd0, "R8 irq drops after clear");
    busRead(4'h4, 32'h8080_0000, "R5 only bit 26 cleared");

    busWrite(4'h4, 32'hFFFF_FFFF);
    @(negedge clk);
    encEvt = 5'b00001; busWrEn = 1'b1; busAddr = 4'h4; busWrData = 32'h0800_0000;
    @(negedge clk);
    encEvt = '0; busWrEn = 1'b0;
    busRead(4'h4, 32'h0800_0000, "R6 event beats same-cycle clear");

    busWrite(4'h0, 32'hF7FF_FFFF);
    @(negedge clk);
    check({31'd0, irqOut}, 32'd1, "R7 unmasked bit 27 raises irq");
    busWrite(4'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    check({31'd0, irqOut}, 32'd0, "R7 closing mask drops irq");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) check(32'(expQ.size()), 32'd0, "R9 reads left unanswered");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule